// File: doc/BRIEF.md
# Serial-Bus Host Interrupt Status and Vector Unit

This unit collects the event flags of a serial-bus host controller into a 16-bit status word. It filters them through a small enable mask and raises a single interrupt line. The transfer engine reports events as one-cycle set pulses, one per status bit. Software clears flags by writing ones to the status register. In legacy mode it can instead read a vector register, which names the lowest-numbered pending enabled source and acknowledges it in the same access.

Two DMA request lines mirror the receive-ready flag (bit 3) and the transmit-ready flag (bit 4). Each line is active only while its direction is switched on in the DMA configuration register. Switching a direction on removes that flag from the interrupt mask, so a flag is not served both by DMA and by interrupt.

Register reads pass through a two-state read port. `RD_IDLE` moves to `RD_RESP` on any cycle with a read strobe. `RD_RESP` stays in `RD_RESP` when a further strobe arrives, and returns to `RD_IDLE` otherwise. The response is valid only in `RD_RESP`.

Top module: `irq_status_vector_unit`

## Requirements
- R1: After reset the status word, enable mask and DMA configuration are zero. The interrupt line, both DMA requests and the read-valid output are low.
- R2: A set pulse on bit i sets status bit i at the next clock edge. From that edge on, `irq` is high exactly when status bits [MASK_W-1:0] AND the mask is nonzero.
- R3: `dma_rx_req` equals status bit 3 while DMA-config bit 15 is set, and is low otherwise. `dma_tx_req` equals status bit 4 while DMA-config bit 7 is set, and is low otherwise.
- R4: A write to the DMA-config register (select 2) stores only bits 15 and 7. A 1 in bit 15 clears mask bit 3, and a 1 in bit 7 clears mask bit 4.
- R5: In newer mode (LEGACY=0), a write to the status register (select 0) clears the status bits among 0, 1, 2 and 5 that are written as 1 (mask 0x0027). Bits 3 and 4 are never cleared by a write. In legacy mode a status write has no effect.
- R6: A status read returns the stored status with bit 12 replaced by the value of `bus_busy` in the read cycle.
- R7: In legacy mode a vector read (select 3) returns (index + 1) of the lowest set bit of status AND mask, and clears that status bit. It returns 0 when nothing is pending. In newer mode a vector read returns 0 and clears nothing.
- R8: A write to the self-test register (select 4) with bit 11 set forces status bits 5:0 to 1.
- R9: A write to the enable register (select 1) keeps the low MASK_W bits: 6 in newer mode, 5 in legacy mode. A read of select 1 returns them.
- R10: `rd_data` and `rd_valid` appear one cycle after the cycle with `rd_en` high. `rd_valid` is high for one cycle per read. Selects 4 to 7 read as 0.
- R11: When a set pulse and a clear of the same status bit fall in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_pulse | input | 16 | One-cycle set request for each status bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select: 0 status, 1 enable, 2 DMA config, 3 vector, 4 self-test |
| wr_data | input | 16 | Write data |
| bus_busy | input | 1 | Live bus-busy flag, merged into status reads |
| rd_data | output | 16 | Read response data |
| rd_valid | output | 1 | Read response valid |
| irq | output | 1 | Combined interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
Status, mask and DMA-config updates take effect at the first clock edge after the strobe or pulse. The interrupt and DMA lines settle combinationally from those registers, so they are checked at the falling edge that follows that rising edge. Read responses come out of a register and are due one cycle after the strobe cycle. The driver queues each expected read value when it raises `rd_en`, and the monitor pops the queue only at falling edges where `rd_valid` is high, so each value is compared in the cycle it is due. A newer-mode instance and a legacy instance share the same stimulus, which exercises both sides of every mode-dependent requirement in one run.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int STAT_W         = 16;
    localparam int RX_READY_BIT   = 3;
    localparam int TX_READY_BIT   = 4;
    localparam int BUSY_BIT       = 12;
    localparam int RX_DMA_BIT     = 15;
    localparam int TX_DMA_BIT     = 7;
    localparam int TEST_FORCE_BIT = 11;
    localparam int FORCE_W        = 6;
    localparam logic [STAT_W-1:0] W1C_BITS = 16'h0027;
    localparam logic [STAT_W-1:0] DMA_BITS = 16'h8080;

    typedef enum logic [2:0] {
        SEL_STATUS   = 3'd0,
        SEL_ENABLE   = 3'd1,
        SEL_DMACFG   = 3'd2,
        SEL_VECTOR   = 3'd3,
        SEL_SELFTEST = 3'd4
    } reg_sel_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/irqv_status_bank.sv
module irqv_status_bank
    import irqv_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_pulse,
    input  logic              status_wr,
    input  logic              test_wr,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [STAT_W-1:0] ack_clr,
    output logic [STAT_W-1:0] status_q
);
    logic [STAT_W-1:0] wr_clear;
    logic [STAT_W-1:0] force_set;
    logic [STAT_W-1:0] status_d;

    // write-one-to-clear is honoured only in newer mode
    assign wr_clear  = (status_wr && !LEGACY) ? (wr_data & W1C_BITS) : '0;
    assign force_set = (test_wr && wr_data[TEST_FORCE_BIT])
                       ? STAT_W'((1 << FORCE_W) - 1) : '0;

    // clears first, then sets: a set in the same cycle wins
    always_comb begin
        status_d = status_q & ~ack_clr & ~wr_clear;
        status_d = status_d | force_set | set_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end
endmodule

// File: rtl/irqv_enable_bank.sv
module irqv_enable_bank
    import irqv_pkg::*;
#(
    parameter int MASK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_wr,
    input  logic              dma_wr,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [MASK_W-1:0] status_lo,
    output logic [MASK_W-1:0] mask_q,
    output logic [STAT_W-1:0] dma_q,
    output logic              irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    logic [STAT_W-1:0] dma_d;
    assign dma_d = wr_data & DMA_BITS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            dma_q  <= '0;
        end else if (enable_wr) begin
            mask_q <= wr_data[MASK_W-1:0];
        end else if (dma_wr) begin
            dma_q <= dma_d;
            if (dma_d[RX_DMA_BIT]) mask_q[RX_READY_BIT] <= 1'b0;
            if (dma_d[TX_DMA_BIT]) mask_q[TX_READY_BIT] <= 1'b0;
        end
    end

    assign irq        = |(status_lo & mask_q);
    assign dma_rx_req = dma_q[RX_DMA_BIT] & status_lo[RX_READY_BIT];
    assign dma_tx_req = dma_q[TX_DMA_BIT] & status_lo[TX_READY_BIT];
endmodule

// File: rtl/irqv_read_port.sv
module irqv_read_port
    import irqv_pkg::*;
#(
    parameter bit LEGACY = 1'b0,
    parameter int MASK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [2:0]        reg_sel,
    input  logic              bus_busy,
    input  logic [STAT_W-1:0] status_q,
    input  logic [MASK_W-1:0] mask_q,
    input  logic [STAT_W-1:0] dma_q,
    output logic [STAT_W-1:0] ack_clr,
    output logic [STAT_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int IDX_W = $clog2(MASK_W);

    rd_state_e         state_q, state_d;
    logic [STAT_W-1:0] data_q, rd_mux;
    logic [MASK_W-1:0] pending;
    logic              vec_hit;
    logic [IDX_W-1:0]  vec_idx;
    logic [STAT_W-1:0] vec_val;
    logic [STAT_W-1:0] status_rd;
    logic              vec_rd;

    assign pending = status_q[MASK_W-1:0] & mask_q;

    // lowest-numbered pending source wins
    always_comb begin
        vec_hit = 1'b0;
        vec_idx = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (pending[i]) begin
                vec_hit = 1'b1;
                vec_idx = IDX_W'(i);
            end
        end
    end

    assign vec_rd  = rd_en && (reg_sel == SEL_VECTOR) && LEGACY;
    assign vec_val = (vec_rd && vec_hit) ? (STAT_W'(vec_idx) + STAT_W'(1)) : '0;
    assign ack_clr = (vec_rd && vec_hit) ? (STAT_W'(1) << vec_idx) : '0;

    always_comb begin
        status_rd           = status_q;
        status_rd[BUSY_BIT] = bus_busy;
    end

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_STATUS: rd_mux = status_rd;
            SEL_ENABLE: rd_mux = STAT_W'(mask_q);
            SEL_DMACFG: rd_mux = dma_q;
            SEL_VECTOR: rd_mux = vec_val;
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_en) state_d = RD_RESP;
            RD_RESP: if (!rd_en) state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) data_q <= rd_mux;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            RD_IDLE: ;
            RD_RESP: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
        endcase
    end
endmodule

// File: rtl/irq_status_vector_unit.sv
module irq_status_vector_unit
    import irqv_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] set_pulse,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  reg_sel,
    input  logic [15:0] wr_data,
    input  logic        bus_busy,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    output logic        irq,
    output logic        dma_rx_req,
    output logic        dma_tx_req
);
    localparam int MASK_W = LEGACY ? 5 : 6;

    logic [STAT_W-1:0] status_q;
    logic [MASK_W-1:0] mask_q;
    logic [STAT_W-1:0] dma_q;
    logic [STAT_W-1:0] ack_clr;
    logic status_wr, enable_wr, dma_wr, test_wr;

    assign status_wr = wr_en && (reg_sel == SEL_STATUS);
    assign enable_wr = wr_en && (reg_sel == SEL_ENABLE);
    assign dma_wr    = wr_en && (reg_sel == SEL_DMACFG);
    assign test_wr   = wr_en && (reg_sel == SEL_SELFTEST);

    irqv_status_bank #(.LEGACY(LEGACY)) u_status (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse),
        .status_wr(status_wr), .test_wr(test_wr), .wr_data(wr_data),
        .ack_clr(ack_clr), .status_q(status_q)
    );

    irqv_enable_bank #(.MASK_W(MASK_W)) u_enable (
        .clk(clk), .rst_n(rst_n), .enable_wr(enable_wr), .dma_wr(dma_wr),
        .wr_data(wr_data), .status_lo(status_q[MASK_W-1:0]),
        .mask_q(mask_q), .dma_q(dma_q), .irq(irq),
        .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
    );

    irqv_read_port #(.LEGACY(LEGACY), .MASK_W(MASK_W)) u_read (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .reg_sel(reg_sel),
        .bus_busy(bus_busy), .status_q(status_q), .mask_q(mask_q),
        .dma_q(dma_q), .ack_clr(ack_clr), .rd_data(rd_data),
        .rd_valid(rd_valid)
    );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int MASK_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       set_pulse,
    input logic              wr_en,
    input logic              rd_en,
    input logic [2:0]        reg_sel,
    input logic [15:0]       wr_data,
    input logic              rd_valid,
    input logic              dma_rx_req,
    input logic [15:0]       status_q,
    input logic [MASK_W-1:0] mask_q,
    input logic [15:0]       dma_q
);
    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse[0] |=> status_q[0]);

    assert_rx_dma_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_q[15] |-> !dma_rx_req);

    assert_dma_wr_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 3'd2 && wr_data[15]) |=> !mask_q[3]);

    assert_ready_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 3'd0 && status_q[3]) |=> status_q[3]);

    assert_single_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == 3'd3 && set_pulse == 16'd0 && !wr_en)
        |=> ($countones(status_q) + 1 >= $countones($past(status_q))));

    assert_force_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 3'd4 && wr_data[11]) |=> (status_q[5:0] == 6'h3f));

    assert_resp_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_resp_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

bind irq_status_vector_unit irqv_checker #(.MASK_W(MASK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .wr_en(wr_en),
    .rd_en(rd_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .rd_valid(rd_valid), .dma_rx_req(dma_rx_req),
    .status_q(status_q), .mask_q(mask_q), .dma_q(dma_q)
);

// File: tb/irq_status_vector_unit_tb_top.sv
module irq_status_vector_unit_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [15:0] set_pulse, wr_data;
    logic        wr_en, rd_en, bus_busy;
    logic [2:0]  reg_sel;
    logic [15:0] n_rd_data, l_rd_data;
    logic        n_rd_valid, l_rd_valid, n_irq, l_irq;
    logic        n_rx, l_rx, n_tx, l_tx;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [15:0] exp_n;
        logic [15:0] exp_l;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    irq_status_vector_unit #(.LEGACY(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .wr_en(wr_en),
        .rd_en(rd_en), .reg_sel(reg_sel), .wr_data(wr_data),
        .bus_busy(bus_busy), .rd_data(n_rd_data), .rd_valid(n_rd_valid),
        .irq(n_irq), .dma_rx_req(n_rx), .dma_tx_req(n_tx)
    );

    irq_status_vector_unit #(.LEGACY(1'b1)) dut_leg_i (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .wr_en(wr_en),
        .rd_en(rd_en), .reg_sel(reg_sel), .wr_data(wr_data),
        .bus_busy(bus_busy), .rd_data(l_rd_data), .rd_valid(l_rd_valid),
        .irq(l_irq), .dma_rx_req(l_rx), .dma_tx_req(l_tx)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [2:0] sel, logic [15:0] d, logic [15:0] sp);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d; set_pulse = sp;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; set_pulse = '0;
    endtask

    task automatic do_pulse(logic [15:0] sp);
        @(negedge clk);
        set_pulse = sp;
        @(negedge clk);
        set_pulse = '0;
    endtask

    // driver: queue the expected value, the monitor compares when due
    task automatic do_read(logic [2:0] sel, logic busy, logic [15:0] en,
                           logic [15:0] el, string tag);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = sel; bus_busy = busy;
        exp_q.push_back('{exp_n: en, exp_l: el, tag: tag});
        @(negedge clk);
        rd_en = 1'b0; bus_busy = 1'b0;
    endtask

    task automatic check_lines(string tag, logic [2:0] en, logic [2:0] el);
        check({tag, " new"}, 16'({n_irq, n_rx, n_tx}), 16'(en));
        check({tag, " legacy"}, 16'({l_irq, l_rx, l_tx}), 16'(el));
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && (n_rd_valid || l_rd_valid)) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " R10 valid"}, 16'({n_rd_valid, l_rd_valid}), 16'd3);
                check({e.tag, " new"}, n_rd_data, e.exp_n);
                check({e.tag, " legacy"}, l_rd_data, e.exp_l);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; set_pulse = '0; wr_data = '0; wr_en = 1'b0;
        rd_en = 1'b0; bus_busy = 1'b0; reg_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_lines("R1 lines after reset", 3'b000, 3'b000);
        check("R1 rd_valid after reset", 16'({n_rd_valid, l_rd_valid}), 16'd0);
        do_read(3'd0, 1'b0, 16'h0000, 16'h0000, "R1 status");
        do_read(3'd1, 1'b0, 16'h0000, 16'h0000, "R1 enable");
        do_read(3'd2, 1'b0, 16'h0000, 16'h0000, "R1 dmacfg");

        // R9 mask width
        do_write(3'd1, 16'hffff, 16'h0000);
        do_read(3'd1, 1'b0, 16'h003f, 16'h001f, "R9 enable width");
        @(negedge clk);
        check("R10 response one cycle only", 16'({n_rd_valid, l_rd_valid}), 16'd0);

        // R2 bit 5 set: enabled only in newer mode
        do_pulse(16'h0020);
        check_lines("R2 irq bit5", 3'b100, 3'b000);
        do_pulse(16'h000a);
        check_lines("R2 irq bits 1,3", 3'b100, 3'b100);

        // R6 busy merged into bit 12
        do_read(3'd0, 1'b1, 16'h102a, 16'h102a, "R6 status busy");

        // R7 vector reads
        do_read(3'd3, 1'b0, 16'h0000, 16'h0002, "R7 vector first");
        do_read(3'd3, 1'b0, 16'h0000, 16'h0004, "R7 vector second");
        do_read(3'd3, 1'b0, 16'h0000, 16'h0000, "R7 vector empty");
        do_read(3'd0, 1'b0, 16'h002a, 16'h0020, "R7 status after ack");

        // R5 write-one-to-clear
        do_write(3'd0, 16'hffff, 16'h0000);
        do_read(3'd0, 1'b0, 16'h0008, 16'h0020, "R5 status after w1c");

        // R4 DMA config
        do_write(3'd2, 16'hffff, 16'h0000);
        do_read(3'd2, 1'b0, 16'h8080, 16'h8080, "R4 dmacfg bits");
        do_read(3'd1, 1'b0, 16'h0027, 16'h0007, "R4 mask cleared");
        check_lines("R3 rx request", 3'b010, 3'b000);
        do_pulse(16'h0010);
        check_lines("R3 tx request", 3'b011, 3'b001);

        // R8 self-test force
        do_write(3'd4, 16'h0800, 16'h0000);
        check_lines("R8 irq after force", 3'b111, 3'b111);
        do_read(3'd0, 1'b0, 16'h003f, 16'h003f, "R8 status forced");

        // R11 set wins over clear
        do_write(3'd0, 16'h0001, 16'h0001);
        do_read(3'd0, 1'b0, 16'h003f, 16'h003f, "R11 set beats clear");
        do_write(3'd0, 16'h0001, 16'h0000);
        do_read(3'd0, 1'b0, 16'h003e, 16'h003f, "R5 clear bit0");
        do_read(3'd3, 1'b0, 16'h0000, 16'h0001, "R7 vector bit0");
        do_read(3'd0, 1'b0, 16'h003e, 16'h003e, "R7 status after bit0 ack");

        // R10 unused select reads 0
        do_read(3'd5, 1'b0, 16'h0000, 16'h0000, "R10 unused select");

        // R3 DMA off
        do_write(3'd2, 16'h0000, 16'h0000);
        check_lines("R3 requests off", 3'b100, 3'b100);

        repeat (3) @(negedge clk);
        check("R10 all responses seen", 16'(exp_q.size()), 16'd0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule